// File: doc/BRIEF.md
# Unified Data-Space Register Decoder

This block sits between an 8-bit core's load/store unit and everything that can be addressed as a byte. It takes one byte request at a time and sorts it into one of three targets. Addresses 0 to 31 go to the general register file. Addresses 32 to 95 form a 64-byte I/O window. Everything at 96 and above is ordinary data memory.

The top eight I/O offsets, 0x38 to 0x3F (byte addresses 0x58 to 0x5F), are served locally. They hold four extended-page registers, an indirect-jump extension register, the two stack-pointer bytes and the status byte. Writes to the page registers and to the stack-pointer high byte take effect only when the matching feature input is set. All other I/O offsets, and all memory addresses, are passed through to an external byte bus at the unchanged byte address. That bus answers in the same cycle.

Requests arrive on a valid/ready port. A read produces a one-entry response on a valid/ready port in the cycle after it is accepted. A write produces no response. The request port stalls only while the response is valid and not yet taken, so a held response is never overwritten. The current special-register state is available on output pins for the rest of the core.

Top module: `dspace_decoder`

## Requirements
- R1: A request with address below 32 reaches the register file only: `rf_addr` equals the low five address bits. An accepted write pulses `rf_we` with the write data. A read returns `rf_rdata` on `rsp_rdata` in the next cycle.
- R2: A request at an I/O address outside 0x58..0x5F, or at any address of 96 or above, reaches the external bus only. When accepted, `ext_en` is high with `ext_addr` equal to the request address and `ext_we` equal to the request's write flag. A read returns `ext_rdata` in the next cycle.
- R3: Page registers D, X, Y and Z sit at addresses 0x58, 0x59, 0x5A and 0x5B. Their enables are `page_feat` bits 0, 1, 2 and 3. When enabled, a write stores the byte in bits 23:16 of the 24-bit extension, with the low 16 bits at zero. A read returns bits 23:16.
- R4: A page-register write whose enable bit is clear leaves that register unchanged; it holds zero since reset. A read then returns that unchanged value.
- R5: A write to address 0x5C always loads the jump extension (byte to bits 23:16). A read returns that byte.
- R6: A write to address 0x5D replaces stack-pointer bits 7:0 and keeps bits 15:8.
- R7: A write to address 0x5E replaces stack-pointer bits 15:8 only while `sp16_feat` is high. Otherwise it has no effect.
- R8: Address 0x5F is the status byte. A write stores it and a read returns it.
- R9: A request at 0x58..0x5F never raises `ext_en` or `rf_we`.
- R10: After reset, all special registers read zero, `rsp_valid` is low and `req_ready` is high.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response holds its data and `req_ready` is low. A request is accepted in the same cycle that `rsp_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 8 | Read byte |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | 5 | Register-file index |
| rf_wdata | output | 8 | Register-file write byte |
| rf_rdata | input | 8 | Register-file read byte (combinational) |
| ext_en | output | 1 | External access strobe |
| ext_we | output | 1 | External write flag |
| ext_addr | output | 16 | External byte address |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte (same cycle) |
| page_feat | input | 4 | Write enables for page registers D, X, Y, Z |
| sp16_feat | input | 1 | Enables writes to the stack-pointer high byte |
| page_ext | output | 4x24 | Page extensions, index 0 = D to 3 = Z |
| jmp_ext | output | 24 | Indirect-jump extension |
| stack_ptr | output | 16 | Stack pointer |
| status | output | 8 | Status byte |

## Verification
The bench targets the range edges and the gated writes.

- **Range edges.** It drives addresses 31, 32, 0x57, 0x60 and 0x100. A decoder with an off-by-one range check would send one of these to the wrong target and return the wrong byte.
- **Gated page writes.** The page enables are set and cleared around writes. A design that ignores an enable bit would show a nonzero page value where zero is expected.
- **Stack-pointer halves.** A low-byte write follows a high-byte write. A design that clears or overwrites the other half would show a corrupted 16-bit pointer.
- **Back-pressure.** The response is stalled with a second request pending. A design that overwrote the held response, or accepted early, would change `rsp_rdata` during the stall.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  // Where an address lands.
  typedef enum logic [1:0] {
    RGN_GPR     = 2'd0,
    RGN_SPECIAL = 2'd1,
    RGN_EXT     = 2'd2
  } region_e;

  // Special-register slot, in I/O offset order (offset = base + index).
  typedef enum logic [2:0] {
    SPC_PAGE_D = 3'd0,
    SPC_PAGE_X = 3'd1,
    SPC_PAGE_Y = 3'd2,
    SPC_PAGE_Z = 3'd3,
    SPC_JMPX   = 3'd4,
    SPC_SPLO   = 3'd5,
    SPC_SPHI   = 3'd6,
    SPC_STAT   = 3'd7
  } spec_e;

  localparam int NUM_PAGES = 4;
  localparam int BYTE_W    = 8;
  localparam int SP_W      = 16;
  localparam int NUM_SPEC  = 8;

endpackage

// File: rtl/dsd_addr_decode.sv
module dsd_addr_decode
  import dsd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_GPR   = 32,
  parameter int NUM_IO    = 64,
  parameter int SPEC_BASE = 56,
  localparam int GPR_AW   = $clog2(NUM_GPR)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output spec_e             spec_sel,
  output logic [GPR_AW-1:0] gpr_idx
);

  localparam logic [ADDR_W-1:0] IO_LO   = ADDR_W'(NUM_GPR);
  localparam logic [ADDR_W-1:0] IO_HI   = ADDR_W'(NUM_GPR + NUM_IO);
  localparam logic [ADDR_W-1:0] SPEC_LO = ADDR_W'(SPEC_BASE);
  localparam logic [ADDR_W-1:0] SPEC_HI = ADDR_W'(SPEC_BASE + NUM_SPEC);

  logic [ADDR_W-1:0] io_off;

  assign io_off  = addr - IO_LO;
  assign gpr_idx = addr[GPR_AW-1:0];

  always_comb begin
    region   = RGN_EXT;
    spec_sel = SPC_PAGE_D;
    if (addr < IO_LO) begin
      region = RGN_GPR;
    end else if (addr < IO_HI) begin
      if (io_off >= SPEC_LO && io_off < SPEC_HI) begin
        region   = RGN_SPECIAL;
        spec_sel = spec_e'(io_off[2:0]);
      end
    end
  end

endmodule

// File: rtl/dsd_special_regs.sv
module dsd_special_regs
  import dsd_pkg::*;
#(
  parameter int EXT_W = 24
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  spec_e                               sel,
  input  logic [BYTE_W-1:0]                   wdata,
  input  logic [NUM_PAGES-1:0]                page_feat,
  input  logic                                sp16_feat,
  output logic [BYTE_W-1:0]                   rd_data,
  output logic [NUM_PAGES-1:0][EXT_W-1:0]     page_q,
  output logic [EXT_W-1:0]                    jmp_q,
  output logic [SP_W-1:0]                     sp_q,
  output logic [BYTE_W-1:0]                   stat_q
);

  localparam int LOW_W = EXT_W - BYTE_W;

  // One generated register per page slot, each gated by its own enable.
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page_q[g] <= '0;
      end else if (wr_en && sel == spec_e'(g) && page_feat[g]) begin
        page_q[g] <= {wdata, {LOW_W{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jmp_q  <= '0;
      sp_q   <= '0;
      stat_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SPC_JMPX: jmp_q <= {wdata, {LOW_W{1'b0}}};
        SPC_SPLO: sp_q[BYTE_W-1:0] <= wdata;
        SPC_SPHI: if (sp16_feat) sp_q[SP_W-1:BYTE_W] <= wdata;
        SPC_STAT: stat_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SPC_PAGE_D, SPC_PAGE_X, SPC_PAGE_Y, SPC_PAGE_Z:
        rd_data = page_q[sel[1:0]][EXT_W-1 -: BYTE_W];
      SPC_JMPX: rd_data = jmp_q[EXT_W-1 -: BYTE_W];
      SPC_SPLO: rd_data = sp_q[BYTE_W-1:0];
      SPC_SPHI: rd_data = sp_q[SP_W-1:BYTE_W];
      default:  rd_data = stat_q;
    endcase
  end

endmodule

// File: rtl/dsd_rsp_reg.sv
module dsd_rsp_reg
  import dsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_GPR   = 32,
  parameter int NUM_IO    = 64,
  parameter int SPEC_BASE = 56,
  parameter int EXT_W     = 24,
  localparam int GPR_AW   = $clog2(NUM_GPR)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_we,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [7:0]                      req_wdata,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [7:0]                      rsp_rdata,
  output logic                            rf_we,
  output logic [GPR_AW-1:0]               rf_addr,
  output logic [7:0]                      rf_wdata,
  input  logic [7:0]                      rf_rdata,
  output logic                            ext_en,
  output logic                            ext_we,
  output logic [ADDR_W-1:0]               ext_addr,
  output logic [7:0]                      ext_wdata,
  input  logic [7:0]                      ext_rdata,
  input  logic [3:0]                      page_feat,
  input  logic                            sp16_feat,
  output logic [3:0][EXT_W-1:0]           page_ext,
  output logic [EXT_W-1:0]                jmp_ext,
  output logic [15:0]                     stack_ptr,
  output logic [7:0]                      status
);

  region_e           region;
  spec_e             spec_sel;
  logic [GPR_AW-1:0] gpr_idx;
  logic              accept;
  logic [7:0]        spec_rd;
  logic [7:0]        rd_mux;

  dsd_addr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_GPR   (NUM_GPR),
    .NUM_IO    (NUM_IO),
    .SPEC_BASE (SPEC_BASE)
  ) u_dec (
    .addr     (req_addr),
    .region   (region),
    .spec_sel (spec_sel),
    .gpr_idx  (gpr_idx)
  );

  // Stall only while a read result is held un-taken.
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign rf_addr   = gpr_idx;
  assign rf_wdata  = req_wdata;
  assign rf_we     = accept && req_we && (region == RGN_GPR);

  assign ext_en    = accept && (region == RGN_EXT);
  assign ext_we    = req_we;
  assign ext_addr  = req_addr;
  assign ext_wdata = req_wdata;

  dsd_special_regs #(
    .EXT_W (EXT_W)
  ) u_spec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept && req_we && (region == RGN_SPECIAL)),
    .sel       (spec_sel),
    .wdata     (req_wdata),
    .page_feat (page_feat),
    .sp16_feat (sp16_feat),
    .rd_data   (spec_rd),
    .page_q    (page_ext),
    .jmp_q     (jmp_ext),
    .sp_q      (stack_ptr),
    .stat_q    (status)
  );

  always_comb begin
    case (region)
      RGN_GPR:     rd_mux = rf_rdata;
      RGN_SPECIAL: rd_mux = spec_rd;
      default:     rd_mux = ext_rdata;
    endcase
  end

  dsd_rsp_reg u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && !req_we),
    .load_data (rd_mux),
    .out_ready (rsp_ready),
    .out_valid (rsp_valid),
    .out_data  (rsp_rdata)
  );

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_we,
  input logic [ADDR_W-1:0]     req_addr,
  input logic [7:0]            req_wdata,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [7:0]            rsp_rdata,
  input logic                  rf_we,
  input logic                  ext_en,
  input logic [3:0]            page_feat,
  input logic                  sp16_feat,
  input logic [3:0][EXT_W-1:0] page_ext,
  input logic [15:0]           stack_ptr
);

  logic acc;
  logic in_spec;
  assign acc     = req_valid && req_ready;
  assign in_spec = (req_addr >= ADDR_W'(16'h58)) && (req_addr <= ADDR_W'(16'h5F));

  assert_gpr_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr < ADDR_W'(32) |-> !ext_en);

  assert_mem_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr >= ADDR_W'(96) |-> ext_en && !rf_we);

  assert_page_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_we && req_addr == ADDR_W'(16'h59) && !page_feat[1] |=> $stable(page_ext[1]));

  assert_splo_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_we && req_addr == ADDR_W'(16'h5D)
    |=> stack_ptr[7:0] == $past(req_wdata) && stack_ptr[15:8] == $past(stack_ptr[15:8]));

  assert_sphi_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_we && req_addr == ADDR_W'(16'h5E) && !sp16_feat |=> $stable(stack_ptr));

  assert_spec_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_spec |-> !ext_en && !rf_we);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

endmodule

bind dspace_decoder dsd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rf_we     (rf_we),
  .ext_en    (ext_en),
  .page_feat (page_feat),
  .sp16_feat (sp16_feat),
  .page_ext  (page_ext),
  .stack_ptr (stack_ptr)
);

// File: tb/dspace_decoder_tb.sv
module dspace_decoder_tb;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_we = 1'b0;
  logic [15:0]      req_addr = '0;
  logic [7:0]       req_wdata = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic [7:0]       rsp_rdata;
  logic             rf_we;
  logic [4:0]       rf_addr;
  logic [7:0]       rf_wdata;
  logic [7:0]       rf_rdata;
  logic             ext_en;
  logic             ext_we;
  logic [15:0]      ext_addr;
  logic [7:0]       ext_wdata;
  logic [7:0]       ext_rdata;
  logic [3:0]       page_feat = '0;
  logic             sp16_feat = 1'b0;
  logic [3:0][23:0] page_ext;
  logic [23:0]      jmp_ext;
  logic [15:0]      stack_ptr;
  logic [7:0]       status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  // Simple target models: register file returns 0x40+index, bus returns addr^0xA5.
  assign rf_rdata  = 8'h40 + {3'b000, rf_addr};
  assign ext_rdata = ext_addr[7:0] ^ 8'hA5;

  dspace_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .ext_en(ext_en), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .page_feat(page_feat), .sp16_feat(sp16_feat),
    .page_ext(page_ext), .jmp_ext(jmp_ext), .stack_ptr(stack_ptr), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {req(4), we(1), addr(16), wdata(8), feat{sp16,page[3:0]}(5), exp(8)}
  localparam int NV = 27;
  localparam logic [41:0] VEC [NV] = '{
    {4'd3, 1'b1, 16'h0058, 8'h12, 5'h0F, 8'h00}, // R3 write D enabled
    {4'd3, 1'b0, 16'h0058, 8'h00, 5'h0F, 8'h12},
    {4'd4, 1'b1, 16'h0059, 8'h34, 5'h00, 8'h00}, // R4 X disabled
    {4'd4, 1'b0, 16'h0059, 8'h00, 5'h00, 8'h00},
    {4'd3, 1'b1, 16'h005A, 8'h56, 5'h0F, 8'h00}, // R3 Y
    {4'd3, 1'b0, 16'h005A, 8'h00, 5'h0F, 8'h56},
    {4'd3, 1'b1, 16'h005B, 8'h78, 5'h08, 8'h00}, // R3 Z only
    {4'd3, 1'b0, 16'h005B, 8'h00, 5'h08, 8'h78},
    {4'd5, 1'b1, 16'h005C, 8'h9A, 5'h00, 8'h00}, // R5 ungated
    {4'd5, 1'b0, 16'h005C, 8'h00, 5'h00, 8'h9A},
    {4'd6, 1'b1, 16'h005D, 8'hBC, 5'h00, 8'h00}, // R6 low byte
    {4'd6, 1'b0, 16'h005D, 8'h00, 5'h00, 8'hBC},
    {4'd7, 1'b1, 16'h005E, 8'hDE, 5'h00, 8'h00}, // R7 gated off
    {4'd7, 1'b0, 16'h005E, 8'h00, 5'h00, 8'h00},
    {4'd7, 1'b1, 16'h005E, 8'hDE, 5'h10, 8'h00}, // R7 gated on
    {4'd7, 1'b0, 16'h005E, 8'h00, 5'h10, 8'hDE},
    {4'd6, 1'b1, 16'h005D, 8'h11, 5'h10, 8'h00}, // R6 keeps high byte
    {4'd6, 1'b0, 16'h005E, 8'h00, 5'h10, 8'hDE},
    {4'd6, 1'b0, 16'h005D, 8'h00, 5'h10, 8'h11},
    {4'd8, 1'b1, 16'h005F, 8'h83, 5'h00, 8'h00}, // R8
    {4'd8, 1'b0, 16'h005F, 8'h00, 5'h00, 8'h83},
    {4'd1, 1'b0, 16'h0005, 8'h00, 5'h00, 8'h45}, // R1
    {4'd1, 1'b0, 16'h001F, 8'h00, 5'h00, 8'h5F}, // R1 top edge
    {4'd2, 1'b0, 16'h0020, 8'h00, 5'h00, 8'h85}, // R2 first I/O
    {4'd2, 1'b0, 16'h0057, 8'h00, 5'h00, 8'hF2}, // R2 below special set
    {4'd2, 1'b0, 16'h0100, 8'h00, 5'h00, 8'hA5}, // R2 memory
    {4'd2, 1'b0, 16'h0060, 8'h00, 5'h00, 8'hC5}  // R2 first memory
  };

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 page", 32'(page_ext[0] | page_ext[1] | page_ext[2] | page_ext[3]), 32'h0);
    check("R10 sp/stat/jmp", {stack_ptr, status, jmp_ext[23:16]}, 32'h0);
    check("R10 rsp_valid/req_ready", {30'h0, rsp_valid, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      req_valid = 1'b1;
      req_we    = v[37];
      req_addr  = v[36:21];
      req_wdata = v[20:13];
      sp16_feat = v[12];
      page_feat = v[11:8];
      @(negedge clk);
      req_valid = 1'b0;
      if (!v[37])
        check($sformatf("R%0d read %h", v[41:38], v[36:21]),
              {23'h0, rsp_valid, rsp_rdata}, {23'h0, 1'b1, v[7:0]});
    end

    // Whole-state checks after the table
    check("R3 page D extension", 32'(page_ext[0]), 32'h120000);
    check("R4 page X untouched", 32'(page_ext[1]), 32'h0);
    check("R5 jump extension", 32'(jmp_ext), 32'h9A0000);
    check("R6 stack pointer", 32'(stack_ptr), 32'hDE11);
    check("R8 status", 32'(status), 32'h83);

    // R9: special write stays local
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h005B; req_wdata = 8'h01;
    page_feat = 4'h0;
    #5 check("R9 no ext/rf strobe", {30'h0, ext_en, rf_we}, 32'h0);
    @(negedge clk);

    // R1 write strobe
    req_addr = 16'h0003; req_wdata = 8'h77;
    #5 check("R1 rf write", {16'h0, 6'h0, ext_en, rf_we, 3'h0, rf_addr}, {16'h0, 6'h0, 1'b0, 1'b1, 3'h0, 5'd3});
    check("R1 rf wdata", 32'(rf_wdata), 32'h77);
    @(negedge clk);

    // R2 write to non-special I/O and to memory
    req_addr = 16'h0040; req_wdata = 8'h5A;
    #5 check("R2 io forward", {ext_en, ext_we, rf_we, 5'h0, ext_wdata, ext_addr}, {3'b110, 5'h0, 8'h5A, 16'h0040});
    @(negedge clk);
    req_addr = 16'h0060;
    #5 check("R2 mem forward", {ext_en, ext_we, rf_we, 13'h0, ext_addr}, {3'b110, 13'h0, 16'h0060});
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;

    // R11 back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 16'h005F;
    @(negedge clk);
    req_addr = 16'h005D;
    #5 check("R11 stall", {22'h0, req_ready, rsp_valid, rsp_rdata}, {22'h0, 1'b0, 1'b1, 8'h83});
    @(negedge clk);
    check("R11 held", {23'h0, rsp_valid, rsp_rdata}, {23'h0, 1'b1, 8'h83});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next accepted", {23'h0, rsp_valid, rsp_rdata}, {23'h0, 1'b1, 8'h11});
    @(negedge clk);
    check("R11 drained", {31'h0, rsp_valid}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule